// File: doc/BRIEF.md
# ISA to CompactFlash Byte-Mode IO Decoder

This block sits between an 8-bit ISA IO slot and a CompactFlash card wired for True-IDE operation with the card set to 8-bit transfers. Every ISA IO cycle therefore moves one byte, and no high-byte latch exists. The block turns the ISA address, AEN and the two IO strobes into the card's two chip selects, its three register-address lines and its read and write strobes. It also steers the byte between the two data buses.

The ISA strobes give no hint of direction while the address is being set up, so the decoder takes the direction from the address itself. The 32-byte window at 300h is split by A4. The lower half (300h-30Fh) is the read group and the upper half (310h-31Fh) is the write group. In the write group the A0 mapping of the two chip selects is swapped, which puts the write that starts a transfer on the odd port. Chip selects and register address are registered from the address alone. A strobe reaches the card only after that selection has held steady for a set number of clocks.

One unused read port returns a fixed identification byte so that host firmware can find the adapter.

Top module: `isa_cf_iodecode`

## Requirements
- R1: A cycle is decoded only when AEN is low and A9..A5 equal 11000b (window 300h-31Fh). Any other address, or AEN high, keeps /CS0 and /CS1 high and both strobes high, and leaves both data-bus enables low even while /IOR or /IOW is low.
- R2: Chip selects come from address and AEN only, one clock after the address is applied, and at most one is low. In the read group (A4=0), A0=0 selects /CS0 and A0=1 selects /CS1. In the write group (A4=1), A0=1 selects /CS0 and A0=0 selects /CS1.
- R3: The register address DA2..DA0 equals A3..A1, one clock after the address is applied.
- R4: /DIOR goes low only while /IOR is low on a decoded read-group address other than the ID port. A low /IOW on a read-group address has no effect.
- R5: /DIOW goes low only while /IOW is low on a decoded write-group address. A low /IOR on a write-group address has no effect.
- R6: A strobe is never driven until the selection has held for SETTLE_CYC clocks. With SETTLE_CYC=2, a strobe applied together with a new address appears after the fourth clock edge and not before. /DIOR and /DIOW are never low together, and the chip selects and DA do not change on the edge where /DIOR falls.
- R7: A read of the ID port 309h drives the ISA bus with ID_VALUE (default 5Ch) and enables the ISA driver. Both chip selects and /DIOR stay high during that read.
- R8: While /DIOR is low, the ISA bus is driven with the card's data byte. The ISA and card drivers are never enabled together.
- R9: While /DIOW is low, the card bus is driven with the ISA data byte. At all other times the card driver is off.
- R10: After reset, both chip selects and both strobes are high and both data-bus enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decode clock |
| rst_n | input | 1 | Active-low reset |
| isa_addr | input | 10 | ISA IO address A9..A0 |
| isa_aen | input | 1 | ISA address enable, high during DMA |
| isa_ior_n | input | 1 | ISA IO read strobe, active low |
| isa_iow_n | input | 1 | ISA IO write strobe, active low |
| isa_dq_i | input | 8 | Byte from the ISA data bus |
| isa_dq_o | output | 8 | Byte driven onto the ISA data bus |
| isa_dq_oe | output | 1 | ISA data-bus driver enable |
| ide_dq_i | input | 8 | Byte from the card data bus |
| ide_dq_o | output | 8 | Byte driven onto the card data bus |
| ide_dq_oe | output | 1 | Card data-bus driver enable |
| ide_cs0_n | output | 1 | Task-file chip select, active low |
| ide_cs1_n | output | 1 | Control-block chip select, active low |
| ide_da | output | 3 | Card register address DA2..DA0 |
| ide_dior_n | output | 1 | Card read strobe, active low |
| ide_diow_n | output | 1 | Card write strobe, active low |

## Verification
The bound checker watches every cycle for the following:
- the two chip selects never being low together, and AEN blocking them;
- strobes appearing only after the matching ISA strobe, and only with a chip select present;
- the two strobes and the two bus drivers each staying mutually exclusive;
- chip selects and DA holding still on the edge where /DIOR falls.

Only the bench's scenarios can show that each address lands on the right chip select and DA value, and that the write-group swap is correct. The same applies to the exact clock where a strobe first appears after a new address, a wrong-direction strobe being dropped, the ID byte value, and the data passing through in each direction.

// File: rtl/isa_cf_iodecode.sv
module isa_cf_iodecode #(
  parameter logic [4:0] BASE_SEL   = 5'b11000,
  parameter logic [3:0] ID_OFFSET  = 4'h9,
  parameter logic [7:0] ID_VALUE   = 8'h5C,
  parameter int         SETTLE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] isa_addr,
  input  logic       isa_aen,
  input  logic       isa_ior_n,
  input  logic       isa_iow_n,
  input  logic [7:0] isa_dq_i,
  output logic [7:0] isa_dq_o,
  output logic       isa_dq_oe,
  input  logic [7:0] ide_dq_i,
  output logic [7:0] ide_dq_o,
  output logic       ide_dq_oe,
  output logic       ide_cs0_n,
  output logic       ide_cs1_n,
  output logic [2:0] ide_da,
  output logic       ide_dior_n,
  output logic       ide_diow_n
);

  localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(SETTLE_CYC);
  localparam int SW = 8;
  localparam int S_ID = 7;
  localparam int S_RD = 6;
  localparam int S_WR = 5;
  localparam int S_C1 = 4;
  localparam int S_C0 = 3;

  logic          win, grp_wr, id_hit, ide_hit;
  logic [SW-1:0] sel_d, sel_q;
  logic [CW-1:0] hold_cnt;
  logic          same, settled;
  logic          rd_q, wr_q, idrd_q;

  assign win     = !isa_aen && (isa_addr[9:5] == BASE_SEL);
  assign grp_wr  = isa_addr[4];
  assign id_hit  = win && !grp_wr && (isa_addr[3:0] == ID_OFFSET);
  assign ide_hit = win && !id_hit;

  assign sel_d = {id_hit,
                  ide_hit && !grp_wr,
                  ide_hit && grp_wr,
                  ide_hit && (isa_addr[0] != grp_wr),
                  ide_hit && (isa_addr[0] == grp_wr),
                  isa_addr[3:1]};

  assign same    = (sel_d == sel_q);
  assign settled = (hold_cnt == CMAX) && same;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      hold_cnt <= '0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      idrd_q   <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      hold_cnt <= !same ? '0 : (hold_cnt == CMAX ? hold_cnt : hold_cnt + 1'b1);
      rd_q     <= settled && sel_q[S_RD] && !isa_ior_n;
      wr_q     <= settled && sel_q[S_WR] && !isa_iow_n;
      idrd_q   <= settled && sel_q[S_ID] && !isa_ior_n;
    end
  end

  assign ide_cs0_n  = !sel_q[S_C0];
  assign ide_cs1_n  = !sel_q[S_C1];
  assign ide_da     = sel_q[2:0];
  assign ide_dior_n = !rd_q;
  assign ide_diow_n = !wr_q;

  assign isa_dq_oe  = rd_q || idrd_q;
  assign isa_dq_o   = idrd_q ? ID_VALUE : ide_dq_i;
  assign ide_dq_oe  = wr_q;
  assign ide_dq_o   = isa_dq_i;

endmodule

// File: rtl/isa_cf_iodecode_chk.sv
module isa_cf_iodecode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       isa_aen,
  input logic       isa_ior_n,
  input logic       isa_iow_n,
  input logic       isa_dq_oe,
  input logic       ide_dq_oe,
  input logic       ide_cs0_n,
  input logic       ide_cs1_n,
  input logic [2:0] ide_da,
  input logic       ide_dior_n,
  input logic       ide_diow_n
);

  AST_AEN_BLOCKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(isa_aen) |-> (ide_cs0_n && ide_cs1_n)); // R1

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_cs0_n && !ide_cs1_n)); // R2

  AST_DIOR_NEEDS_IOR: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_dior_n |-> $past(!isa_ior_n)); // R4

  AST_DIOW_NEEDS_IOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_diow_n |-> $past(!isa_iow_n)); // R5

  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_dior_n || !ide_diow_n) |-> (!ide_cs0_n || !ide_cs1_n)); // R4

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_dior_n && !ide_diow_n)); // R6

  AST_CS_STEADY_AT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_dior_n) |-> ($stable(ide_cs0_n) && $stable(ide_cs1_n) && $stable(ide_da))); // R6

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(isa_dq_oe && ide_dq_oe)); // R8

  AST_CARD_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ide_dq_oe |-> $past(!isa_iow_n)); // R9

endmodule

bind isa_cf_iodecode isa_cf_iodecode_chk u_chk (.*);

// File: tb/tb_isa_cf_iodecode.sv
module tb_isa_cf_iodecode;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] isa_addr = 10'h3F0;
  logic       isa_aen = 1'b0;
  logic       isa_ior_n = 1'b1;
  logic       isa_iow_n = 1'b1;
  logic [7:0] isa_dq_i = 8'h00;
  logic [7:0] ide_dq_i = 8'h00;
  logic [7:0] isa_dq_o, ide_dq_o;
  logic       isa_dq_oe, ide_dq_oe, ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n;
  logic [2:0] ide_da;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [7:0] ID_BYTE = 8'h5C;

  always #4 clk = ~clk;

  isa_cf_iodecode dut (
    .clk(clk), .rst_n(rst_n), .isa_addr(isa_addr), .isa_aen(isa_aen),
    .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n), .isa_dq_i(isa_dq_i),
    .isa_dq_o(isa_dq_o), .isa_dq_oe(isa_dq_oe), .ide_dq_i(ide_dq_i),
    .ide_dq_o(ide_dq_o), .ide_dq_oe(ide_dq_oe), .ide_cs0_n(ide_cs0_n),
    .ide_cs1_n(ide_cs1_n), .ide_da(ide_da), .ide_dior_n(ide_dior_n),
    .ide_diow_n(ide_diow_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    isa_addr = 10'h3F0; isa_aen = 1'b0; isa_ior_n = 1'b1; isa_iow_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(ide_cs0_n && ide_cs1_n && ide_dior_n && ide_diow_n && !isa_dq_oe && !ide_dq_oe,
        "R10 reset", {ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, isa_dq_oe, ide_dq_oe}, 6'b111100);
  endtask

  task automatic t_read(input logic [9:0] a, input logic [7:0] d);
    logic e0, e1;
    e0 = (a[0] == 1'b0); e1 = !e0;
    isa_addr = a; ide_dq_i = d;
    repeat (4) @(negedge clk);
    chk({!ide_cs0_n, !ide_cs1_n} == {e0, e1}, "R2 read group cs", {!ide_cs0_n, !ide_cs1_n}, {e0, e1});
    chk(ide_da == a[3:1], "R3 da", ide_da, a[3:1]);
    isa_ior_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!ide_dior_n && ide_diow_n, "R4 dior on read", {ide_dior_n, ide_diow_n}, 2'b01);
    chk(isa_dq_oe && !ide_dq_oe && isa_dq_o == d, "R8 read data", {isa_dq_oe, isa_dq_o}, {1'b1, d});
    isa_ior_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ide_dior_n && !isa_dq_oe, "R8 release", {ide_dior_n, isa_dq_oe}, 2'b10);
    idle(2);
  endtask

  task automatic t_write(input logic [9:0] a, input logic [7:0] d);
    logic e0, e1;
    e0 = (a[0] == 1'b1); e1 = !e0;
    isa_addr = a; isa_dq_i = d;
    repeat (4) @(negedge clk);
    chk({!ide_cs0_n, !ide_cs1_n} == {e0, e1}, "R2 write group cs swap", {!ide_cs0_n, !ide_cs1_n}, {e0, e1});
    chk(ide_da == a[3:1], "R3 da", ide_da, a[3:1]);
    isa_iow_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!ide_diow_n && ide_dior_n, "R5 diow on write", {ide_dior_n, ide_diow_n}, 2'b10);
    chk(ide_dq_oe && !isa_dq_oe && ide_dq_o == d, "R9 write data", {ide_dq_oe, ide_dq_o}, {1'b1, d});
    isa_iow_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ide_diow_n && !ide_dq_oe, "R9 release", {ide_diow_n, ide_dq_oe}, 2'b10);
    idle(2);
  endtask

  task automatic t_wrong_dir;
    isa_addr = 10'h302; isa_iow_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(ide_diow_n && ide_dior_n && !ide_dq_oe, "R4 iow in read group ignored",
        {ide_diow_n, ide_dior_n, ide_dq_oe}, 3'b110);
    idle(2);
    isa_addr = 10'h313; isa_ior_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(ide_dior_n && ide_diow_n && !isa_dq_oe, "R5 ior in write group ignored",
        {ide_dior_n, ide_diow_n, isa_dq_oe}, 3'b110);
    idle(2);
  endtask

  task automatic t_outside(input logic [9:0] a, input logic aen);
    isa_addr = a; isa_aen = aen; isa_ior_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(ide_cs0_n && ide_cs1_n && ide_dior_n && !isa_dq_oe, "R1 outside window read",
        {ide_cs0_n, ide_cs1_n, ide_dior_n, isa_dq_oe}, 4'b1110);
    idle(2);
    isa_addr = a; isa_aen = aen; isa_iow_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(ide_cs0_n && ide_cs1_n && ide_diow_n && !ide_dq_oe, "R1 outside window write",
        {ide_cs0_n, ide_cs1_n, ide_diow_n, ide_dq_oe}, 4'b1110);
    idle(2);
  endtask

  task automatic t_id;
    isa_addr = 10'h309; ide_dq_i = 8'hE7;
    repeat (4) @(negedge clk);
    chk(ide_cs0_n && ide_cs1_n, "R7 id port no cs", {ide_cs0_n, ide_cs1_n}, 2'b11);
    isa_ior_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(isa_dq_oe && isa_dq_o == ID_BYTE, "R7 id value", {isa_dq_oe, isa_dq_o}, {1'b1, ID_BYTE});
    chk(ide_dior_n, "R7 id no dior", ide_dior_n, 1);
    idle(2);
  endtask

  task automatic t_settle;
    isa_addr = 10'h307; isa_ior_n = 1'b0; ide_dq_i = 8'h3C;
    @(negedge clk);
    chk(!ide_cs1_n && ide_cs0_n && ide_da == 3'd3, "R2 cs one clock after address",
        {ide_cs0_n, ide_cs1_n, ide_da}, {2'b10, 3'd3});
    chk(ide_dior_n, "R6 no strobe after 1 edge", ide_dior_n, 1);
    repeat (2) @(negedge clk);
    chk(ide_dior_n, "R6 no strobe after 3 edges", ide_dior_n, 1);
    @(negedge clk);
    chk(!ide_dior_n && isa_dq_o == 8'h3C, "R6 strobe after 4 edges", {ide_dior_n, isa_dq_o}, {1'b0, 8'h3C});
    idle(2);
    isa_addr = 10'h314; isa_iow_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ide_diow_n, "R6 no write strobe after 3 edges", ide_diow_n, 1);
    @(negedge clk);
    chk(!ide_diow_n, "R6 write strobe after 4 edges", ide_diow_n, 0);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_read(10'h300, 8'hA1);
    t_read(10'h301, 8'h1F);
    t_read(10'h30E, 8'h77);
    t_read(10'h30F, 8'h80);
    t_write(10'h310, 8'h42);
    t_write(10'h311, 8'hC3);
    t_write(10'h31A, 8'h0D);
    t_write(10'h31F, 8'hFE);
    t_wrong_dir();
    t_outside(10'h2F0, 1'b0);
    t_outside(10'h320, 1'b0);
    t_outside(10'h300, 1'b1);
    t_outside(10'h311, 1'b1);
    t_id();
    t_settle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; failures++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule